// File: doc/BRIEF.md
# Dual-Channel Sensor Interrupt Controller

This block turns two streams of sensor results into one active-low interrupt request. The first stream carries 12-bit ambient-light values and the second carries 8-bit proximity values. Each value arrives with a one-cycle strobe. The light channel tests each value against a programmable window. It raises a sticky flag once enough results in a row fall outside that window, and only software can lower the flag again. The proximity channel has hysteresis. Its flag rises after a run of results at or above a high threshold, and it falls by itself after a run of results at or below a low threshold.

Each channel has its own run-length filter with a selectable length. The two flags are merged into the interrupt pin by either an OR or an AND, chosen by one control bit. The host lowers a flag by writing 0 to the matching flag bit. The light thresholds come in as three byte-wide register images, and the block rebuilds the two 12-bit limits from them.

Top module: `sensor_irq_ctrl`

## Requirements
- R1: The light low limit is {lt_mid_byte[3:0], lt_low_byte[7:0]}. The light high limit is {lt_high_byte[7:0], lt_mid_byte[7:4]}.
- R2: A light result counts as out of window when it is less than or equal to the low limit, or greater than or equal to the high limit. A result strictly between the two limits never counts as out of window.
- R3: The run length is chosen per channel by a 2-bit code. Code 0 needs 1 qualifying result, code 1 needs 4, code 2 needs 8 and code 3 needs 16. lt_persist selects the light length and px_persist selects the proximity length.
- R4: Once set, the light flag stays set whatever results arrive, until the host clears it.
- R5: A host write (host_wr high) with host_lt_bit at 0 clears the light flag, and with host_px_bit at 0 it clears the proximity flag. A bit at 1 leaves its flag unchanged.
- R6: While the proximity flag is clear, it sets after N consecutive results at or above px_high.
- R7: While the proximity flag is set, it clears after N consecutive results at or below px_low.
- R8: A strobed result that fails its channel's current condition restarts the run count. The run count also restarts whenever the proximity flag changes value.
- R9: With combine_and at 0, irq_n is low when either flag is set. With combine_and at 1, irq_n is low only when both flags are set.
- R10: When a flag update from a result and a host clear of the same flag happen in the same cycle, the result's update takes effect.
- R11: Synchronous active-low reset clears both flags and both run counts, so irq_n reads high after reset.
- R12: Result values presented without their strobe have no effect on flags or run counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lt_valid | input | 1 | New light result strobe |
| lt_result | input | 12 | Light result value |
| px_valid | input | 1 | New proximity result strobe |
| px_result | input | 8 | Proximity result value |
| lt_low_byte | input | 8 | Light low limit bits 7:0 |
| lt_mid_byte | input | 8 | Low nibble: low limit bits 11:8; high nibble: high limit bits 3:0 |
| lt_high_byte | input | 8 | Light high limit bits 11:4 |
| px_low | input | 8 | Proximity low threshold |
| px_high | input | 8 | Proximity high threshold |
| lt_persist | input | 2 | Light run-length code |
| px_persist | input | 2 | Proximity run-length code |
| combine_and | input | 1 | 0: OR of flags, 1: AND of flags |
| host_wr | input | 1 | Host write strobe to the flag register |
| host_lt_bit | input | 1 | Written light flag value (0 clears) |
| host_px_bit | input | 1 | Written proximity flag value (0 clears) |
| lt_flag | output | 1 | Sticky light flag |
| px_flag | output | 1 | Proximity flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume the threshold and control fields are stable registered values and that each strobe is sampled on a clock edge. They also assume a flag can only change in a cycle that carries a strobe or a host write. The bench drives every input just after a falling edge and holds it through the next rising edge, so these assumptions hold. It reprograms thresholds and run-length codes only between strobes. The random phase keeps px_low below px_high, so the hysteresis conditions do not overlap.

// File: rtl/sir_pkg.sv
// Shared constants and helpers for the sensor interrupt controller.
// Assumes run-length codes are 2 bits wide, with the longest run set by PERSIST_MAX.
package sir_pkg;
    localparam int PERSIST_MAX = 16;
    localparam int PCNT_W      = $clog2(PERSIST_MAX + 1);
    localparam int LT_W        = 12;
    localparam int PX_W        = 8;
    localparam int REG_W       = 8;

    // Map a run-length code to the number of consecutive results it needs.
    function automatic logic [PCNT_W-1:0] persist_len(input logic [1:0] code);
        logic [PCNT_W-1:0] len;
        case (code)
            2'd0:    len = PCNT_W'(1);
            2'd1:    len = PCNT_W'(4);
            2'd2:    len = PCNT_W'(8);
            default: len = PCNT_W'(PERSIST_MAX);
        endcase
        return len;
    endfunction
endpackage

// File: rtl/sir_persist.sv
// Consecutive-result filter. It counts strobed samples that meet a condition,
// saturates at the needed length and restarts on a failing sample or on request.
// Assumes need is at least 1. hit is combinational for the current sample.
module sir_persist #(
    parameter int W = sir_pkg::PCNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         qualify,
    input  logic         restart,
    input  logic [W-1:0] need,
    output logic         hit
);
    logic [W-1:0] cnt;
    logic [W:0]   run_len;

    // Length the run would reach if this sample qualifies.
    always_comb begin
        run_len = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
        hit     = sample && qualify && (run_len >= {1'b0, need});
    end

    // Run counter: restart, reset on a failing sample, else count up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (sample) begin
            if (!qualify)
                cnt <= '0;
            else if (cnt < need)
                cnt <= run_len[W-1:0];
        end
    end
endmodule

// File: rtl/sir_light_chan.sv
// Light channel: rebuilds the 12-bit window limits from three register bytes,
// tests each strobed result against the window, and holds a sticky flag that
// only the host can clear. An event from a result takes priority over a host clear.
module sir_light_chan
    import sir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [LT_W-1:0]  result,
    input  logic [REG_W-1:0] low_byte,
    input  logic [REG_W-1:0] mid_byte,
    input  logic [REG_W-1:0] high_byte,
    input  logic [1:0]       persist,
    input  logic             host_clr,
    output logic             flag
);
    logic [LT_W-1:0] lim_lo;
    logic [LT_W-1:0] lim_hi;
    logic            outside;
    logic            hit;

    // Assemble the limits and evaluate the window test.
    always_comb begin
        lim_lo  = {mid_byte[3:0], low_byte};
        lim_hi  = {high_byte, mid_byte[7:4]};
        outside = (result <= lim_lo) || (result >= lim_hi);
    end

    sir_persist #(.W(PCNT_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (valid),
        .qualify (outside),
        .restart (1'b0),
        .need    (persist_len(persist)),
        .hit     (hit)
    );

    // Sticky flag: set by a full run, cleared only by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (host_clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/sir_prox_chan.sv
// Proximity channel with hysteresis. While the flag is clear it counts results
// at or above the high threshold; while set it counts results at or below the
// low threshold. A full run toggles the flag. The run restarts when the flag changes.
module sir_prox_chan
    import sir_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [PX_W-1:0] result,
    input  logic [PX_W-1:0] thr_low,
    input  logic [PX_W-1:0] thr_high,
    input  logic [1:0]      persist,
    input  logic            host_clr,
    output logic            flag
);
    logic qual;
    logic hit;
    logic flag_nxt;

    // Pick the condition that applies in the current flag state.
    always_comb begin
        qual = flag ? (result <= thr_low) : (result >= thr_high);
    end

    // Next flag value: a completed run wins over a host clear.
    always_comb begin
        if (hit)
            flag_nxt = !flag;
        else if (host_clr)
            flag_nxt = 1'b0;
        else
            flag_nxt = flag;
    end

    sir_persist #(.W(PCNT_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (valid),
        .qualify (qual),
        .restart (flag_nxt != flag),
        .need    (persist_len(persist)),
        .hit     (hit)
    );

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= flag_nxt;
    end
endmodule

// File: rtl/sensor_irq_ctrl.sv
// Top of the sensor interrupt controller. It holds one light and one proximity
// channel and merges their flags into an active-low request with OR or AND.
// Assumes the register fields are static around strobes, and that a host write
// strobe covers only the flag register.
module sensor_irq_ctrl
    import sir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lt_valid,
    input  logic [LT_W-1:0]  lt_result,
    input  logic             px_valid,
    input  logic [PX_W-1:0]  px_result,
    input  logic [REG_W-1:0] lt_low_byte,
    input  logic [REG_W-1:0] lt_mid_byte,
    input  logic [REG_W-1:0] lt_high_byte,
    input  logic [PX_W-1:0]  px_low,
    input  logic [PX_W-1:0]  px_high,
    input  logic [1:0]       lt_persist,
    input  logic [1:0]       px_persist,
    input  logic             combine_and,
    input  logic             host_wr,
    input  logic             host_lt_bit,
    input  logic             host_px_bit,
    output logic             lt_flag,
    output logic             px_flag,
    output logic             irq_n
);
    logic lt_clr;
    logic px_clr;

    // Decode the host clears: writing 0 to a flag bit clears that flag.
    always_comb begin
        lt_clr = host_wr && !host_lt_bit;
        px_clr = host_wr && !host_px_bit;
    end

    sir_light_chan u_light (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (lt_valid),
        .result    (lt_result),
        .low_byte  (lt_low_byte),
        .mid_byte  (lt_mid_byte),
        .high_byte (lt_high_byte),
        .persist   (lt_persist),
        .host_clr  (lt_clr),
        .flag      (lt_flag)
    );

    sir_prox_chan u_prox (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (px_valid),
        .result   (px_result),
        .thr_low  (px_low),
        .thr_high (px_high),
        .persist  (px_persist),
        .host_clr (px_clr),
        .flag     (px_flag)
    );

    // Merge the flags into the active-low request.
    always_comb begin
        if (combine_and)
            irq_n = !(lt_flag && px_flag);
        else
            irq_n = !(lt_flag || px_flag);
    end
endmodule

// File: rtl/sir_checker.sv
// Property checker for sensor_irq_ctrl, attached with bind. It only observes.
module sir_checker
    import sir_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lt_valid,
    input logic [LT_W-1:0]  lt_result,
    input logic             px_valid,
    input logic [PX_W-1:0]  px_result,
    input logic [REG_W-1:0] lt_low_byte,
    input logic [REG_W-1:0] lt_mid_byte,
    input logic [REG_W-1:0] lt_high_byte,
    input logic [PX_W-1:0]  px_low,
    input logic [PX_W-1:0]  px_high,
    input logic [1:0]       lt_persist,
    input logic [1:0]       px_persist,
    input logic             combine_and,
    input logic             host_wr,
    input logic             host_lt_bit,
    input logic             host_px_bit,
    input logic             lt_flag,
    input logic             px_flag,
    input logic             irq_n
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!lt_flag && !px_flag));                                   // R11

    AST_LT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_flag && !(host_wr && !host_lt_bit)) |=> lt_flag);                // R4

    AST_LT_SET_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lt_flag && !lt_valid) |=> !lt_flag);                               // R12

    AST_PX_SET_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (!px_flag && !(px_valid && (px_result >= px_high))) |=> !px_flag);   // R6

    AST_PX_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (px_flag && !(px_valid && (px_result <= px_low)) && !(host_wr && !host_px_bit))
        |=> px_flag);                                                         // R7

    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!lt_flag && !px_flag) |-> irq_n);                                    // R9
endmodule

bind sensor_irq_ctrl sir_checker u_sir_checker (.*);

// File: tb/tb_sensor_irq_ctrl.sv
// Self-checking bench: directed scenarios and a random phase, with a behavioural
// reference model compared against the outputs on every falling edge.
module tb_sensor_irq_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lt_valid = 1'b0;
    logic [11:0] lt_result = '0;
    logic        px_valid = 1'b0;
    logic [7:0]  px_result = '0;
    logic [7:0]  lt_low_byte = 8'h00;
    logic [7:0]  lt_mid_byte = 8'hF0;
    logic [7:0]  lt_high_byte = 8'hFF;
    logic [7:0]  px_low = 8'h00;
    logic [7:0]  px_high = 8'hFF;
    logic [1:0]  lt_persist = 2'd0;
    logic [1:0]  px_persist = 2'd0;
    logic        combine_and = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_lt_bit = 1'b1;
    logic        host_px_bit = 1'b1;
    logic        lt_flag;
    logic        px_flag;
    logic        irq_n;

    int  checks = 0;
    int  failures = 0;
    bit  cmp_en = 1'b0;
    bit  done = 1'b0;

    // Reference model state.
    bit  m_lt = 1'b0;
    bit  m_px = 1'b0;
    int  c_lt = 0;
    int  c_px = 0;

    sensor_irq_ctrl dut (.*);

    always #(CLK_P/2) clk = ~clk;

    function automatic int run_need(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (2 << code);
    endfunction

    // Behavioural model, updated on each rising edge from the held inputs.
    always @(posedge clk) begin
        int  n;
        int  lo;
        int  hi;
        bit  hit;
        bit  q;
        bit  old;
        if (!rst_n) begin
            m_lt = 0; m_px = 0; c_lt = 0; c_px = 0;
        end else begin
            n   = run_need(lt_persist);
            lo  = {lt_mid_byte[3:0], lt_low_byte};
            hi  = {lt_high_byte, lt_mid_byte[7:4]};
            hit = 0;
            if (lt_valid) begin
                if (int'(lt_result) <= lo || int'(lt_result) >= hi) begin
                    hit  = (c_lt + 1 >= n);
                    c_lt = (c_lt < n) ? c_lt + 1 : c_lt;
                end else c_lt = 0;
            end
            if (hit) m_lt = 1;
            else if (host_wr && !host_lt_bit) m_lt = 0;

            n   = run_need(px_persist);
            hit = 0;
            if (px_valid) begin
                q = m_px ? (px_result <= px_low) : (px_result >= px_high);
                if (q) begin
                    hit  = (c_px + 1 >= n);
                    c_px = (c_px < n) ? c_px + 1 : c_px;
                end else c_px = 0;
            end
            old = m_px;
            if (hit) m_px = !m_px;
            else if (host_wr && !host_px_bit) m_px = 0;
            if (m_px != old) c_px = 0;
        end
    end

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            check_bit("R4 lt_flag vs model", lt_flag, m_lt);
            check_bit("R7 px_flag vs model", px_flag, m_px);
            check_bit("R9 irq_n vs model", irq_n,
                      combine_and ? !(m_lt && m_px) : !(m_lt || m_px));
        end
    end

    task automatic lt_sample(input logic [11:0] v);
        lt_result = v; lt_valid = 1'b1;
        @(negedge clk);
        lt_valid = 1'b0;
    endtask

    task automatic px_sample(input logic [7:0] v);
        px_result = v; px_valid = 1'b1;
        @(negedge clk);
        px_valid = 1'b0;
    endtask

    task automatic host_write(input logic ltb, input logic pxb);
        host_wr = 1'b1; host_lt_bit = ltb; host_px_bit = pxb;
        @(negedge clk);
        host_wr = 1'b0; host_lt_bit = 1'b1; host_px_bit = 1'b1;
    endtask

    // Clear both flags and restart both runs with in-between samples.
    task automatic settle();
        host_write(1'b0, 1'b0);
        lt_sample(12'h400);
        px_sample(8'h50);
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R11: reset state
        check_bit("R11 lt_flag after reset", lt_flag, 1'b0);
        check_bit("R11 px_flag after reset", px_flag, 1'b0);
        check_bit("R11 irq_n after reset", irq_n, 1'b1);

        // Light limits: low 0x100, high 0x7F5.
        lt_low_byte = 8'h00; lt_mid_byte = 8'h51; lt_high_byte = 8'h7F;
        px_low = 8'h20; px_high = 8'h80;
        lt_persist = 2'd0; px_persist = 2'd0;
        settle();
        lt_sample(12'h101);
        check_bit("R2 inside window", lt_flag, 1'b0);
        lt_sample(12'h100);
        check_bit("R1 R2 at low limit", lt_flag, 1'b1);
        host_write(1'b0, 1'b1);
        check_bit("R5 host clear light", lt_flag, 1'b0);
        lt_sample(12'h7F4);
        check_bit("R1 below high nibble limit", lt_flag, 1'b0);
        lt_sample(12'h7F5);
        check_bit("R1 R2 at high limit", lt_flag, 1'b1);
        // R4: in-window results keep the flag
        lt_sample(12'h400);
        lt_sample(12'h300);
        check_bit("R4 sticky after inside results", lt_flag, 1'b1);
        // R12: no strobe, no effect
        host_write(1'b0, 1'b1);
        lt_result = 12'h000; px_result = 8'hFF;
        repeat (4) @(negedge clk);
        check_bit("R12 light unstrobed", lt_flag, 1'b0);
        check_bit("R12 prox unstrobed", px_flag, 1'b0);

        // R3: run lengths 4, 8, 16 on the light channel.
        for (int code = 1; code < 4; code++) begin
            settle();
            lt_persist = 2'(code);
            for (int k = 0; k < run_need(2'(code)) - 1; k++) lt_sample(12'hFFF);
            check_bit("R3 light one short of run", lt_flag, 1'b0);
            lt_sample(12'hFFF);
            check_bit("R3 light run complete", lt_flag, 1'b1);
        end
        // R8: an inside result restarts the run.
        settle();
        lt_persist = 2'd1;
        repeat (3) lt_sample(12'h000);
        lt_sample(12'h400);
        repeat (3) lt_sample(12'h000);
        check_bit("R8 light run restarted", lt_flag, 1'b0);
        lt_sample(12'h000);
        check_bit("R8 light run after restart", lt_flag, 1'b1);

        // R6 and R7: proximity hysteresis with a run of 4.
        settle();
        px_persist = 2'd1;
        repeat (3) px_sample(8'h80);
        check_bit("R6 prox one short", px_flag, 1'b0);
        px_sample(8'h80);
        check_bit("R6 prox set at high", px_flag, 1'b1);
        repeat (3) px_sample(8'h20);
        px_sample(8'h50);
        check_bit("R8 prox between restarts clear run", px_flag, 1'b1);
        repeat (3) px_sample(8'h10);
        check_bit("R7 prox one short of clear", px_flag, 1'b1);
        px_sample(8'h20);
        check_bit("R7 prox auto clear at low", px_flag, 1'b0);

        // R9: combine modes.
        settle();
        lt_persist = 2'd0; px_persist = 2'd0;
        lt_sample(12'hFFF);
        combine_and = 1'b0;
        @(negedge clk);
        check_bit("R9 OR with light only", irq_n, 1'b0);
        combine_and = 1'b1;
        @(negedge clk);
        check_bit("R9 AND with light only", irq_n, 1'b1);
        px_sample(8'hC0);
        check_bit("R9 AND with both", irq_n, 1'b0);
        // R5: writing 1 keeps flags, 0 clears only the chosen one
        host_write(1'b1, 1'b1);
        check_bit("R5 write ones keeps light", lt_flag, 1'b1);
        check_bit("R5 write ones keeps prox", px_flag, 1'b1);
        host_write(1'b1, 1'b0);
        check_bit("R5 prox cleared", px_flag, 1'b0);
        check_bit("R5 light untouched", lt_flag, 1'b1);
        combine_and = 1'b0;

        // R10: result event beats host clear in the same cycle.
        settle();
        lt_result = 12'h000; lt_valid = 1'b1;
        px_result = 8'hF0; px_valid = 1'b1;
        host_wr = 1'b1; host_lt_bit = 1'b0; host_px_bit = 1'b0;
        @(negedge clk);
        lt_valid = 1'b0; px_valid = 1'b0;
        host_wr = 1'b0; host_lt_bit = 1'b1; host_px_bit = 1'b1;
        check_bit("R10 light set beats clear", lt_flag, 1'b1);
        check_bit("R10 prox set beats clear", px_flag, 1'b1);

        // Random phase checked by the model every cycle.
        for (int i = 0; i < 6000; i++) begin
            if (i % 400 == 0) begin
                lt_low_byte  = 8'($urandom_range(0, 255));
                lt_mid_byte  = {4'($urandom_range(4, 15)), 4'($urandom_range(0, 3))};
                lt_high_byte = 8'($urandom_range(96, 255));
                px_low       = 8'($urandom_range(0, 100));
                px_high      = 8'($urandom_range(120, 255));
                lt_persist   = 2'($urandom_range(0, 3));
                px_persist   = 2'($urandom_range(0, 3));
                combine_and  = 1'($urandom_range(0, 1));
            end
            lt_valid  = 1'($urandom_range(0, 1));
            lt_result = ($urandom_range(0, 2) == 0) ? 12'($urandom_range(0, 4095))
                      : (($urandom_range(0, 1) == 0) ? 12'($urandom_range(0, 600))
                                                     : 12'($urandom_range(3000, 4095)));
            px_valid  = 1'($urandom_range(0, 1));
            px_result = 8'($urandom_range(0, 255));
            host_wr   = ($urandom_range(0, 31) == 0);
            host_lt_bit = 1'($urandom_range(0, 1));
            host_px_bit = 1'($urandom_range(0, 1));
            @(negedge clk);
        end
        lt_valid = 1'b0; px_valid = 1'b0; host_wr = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule